// File: doc/BRIEF.md
# Paired-Page TLB Lookup Engine

This block is a fully associative translation buffer whose every slot maps two neighbouring virtual pages, an even one and an odd one, that share one virtual tag. Each slot carries its own page-size mask, so slots of 4 KB up to 16 MB pages coexist. Software-side logic loads a slot through a write port addressed by slot number. A lookup is started with a one-cycle pulse carrying the virtual address, the current address-space identifier and the access direction.

The engine walks the slots one per clock. The walk begins at the slot written most recently, wraps from the last slot to slot 0, and stops at the first slot that matches. A one-cycle done pulse comes with either a physical address and a writable bit, or an exception code and a refill flag. The caller uses the exception code and refill flag to choose between the fast refill path and the general fault path.

Top module: `pair_tlb`

## Requirements
- R1: After reset `done`, `xlatOk`, `excValid`, `refill` and `cfgErr` are 0, every slot is invalid, and the first walk starts at slot 0.
- R2: A walk visits slots in the order s, s+1, …, N-1, 0, …, s-1, where s is the slot of the most recent write. When the slot at walk position k (0-based) matches, `done` rises on the (k+1)-th rising edge after the edge that accepted `start`.
- R3: The page shift comes from the slot's mask ORed with 0x1FFF. The values 0x1FFF, 0x7FFF, 0x1FFFF, 0x7FFFF, 0x1FFFFF, 0x7FFFFF and 0x1FFFFFF give shifts 12, 14, 16, 18, 20, 22 and 24. Address bit [shift] set selects the odd half of the slot, which supplies its own PFN, valid and dirty bits.
- R4: A slot matches when the address bits above position shift agree with the slot's tag (tag held as address bits [31:13]). The ASID must also be equal, unless the slot's global bit is set.
- R5: On a match with valid=1 and no modify fault, `xlatOk`=1. `paddr` = ((PFN·4096) with the low shift bits cleared) | (vaddr & (2^shift−1)), and `writable` equals the selected dirty bit.
- R6: On a match with valid=0, `excValid`=1 and `refill`=0. `excCode` is 2 for a read and 3 for a write.
- R7: On a match with valid=1, dirty=0 and a write access, `excCode`=1 and `refill`=0. A read of the same page succeeds with `writable`=0.
- R8: When no slot matches, `done` rises N edges after the accepting edge, with `excValid`=1, `refill`=1, and `excCode` equal to 2 for a read or 3 for a write.
- R9: A walk ends at the first matching slot in walk order. When two slots match, the one visited first wins.
- R10: A slot written with an unsupported mask translates as 4 KB pages, and `cfgErr` goes to 1 and stays 1 until reset.
- R11: A `start` pulse that arrives while a walk is in progress is ignored and does not change the result of that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Slot write strobe |
| wrIdx | input | IDX_W | Slot number to write |
| wrMask | input | 25 | Page-size mask |
| wrVpn2 | input | VA_W-13 | Pair tag (address bits [VA_W-1:13]) |
| wrAsid | input | ASID_W | Slot ASID |
| wrGlobal | input | 1 | Ignore ASID on match |
| wrPfn0 | input | PFN_W | Even page frame number |
| wrValid0 | input | 1 | Even page valid |
| wrDirty0 | input | 1 | Even page writable |
| wrPfn1 | input | PFN_W | Odd page frame number |
| wrValid1 | input | 1 | Odd page valid |
| wrDirty1 | input | 1 | Odd page writable |
| start | input | 1 | Lookup request pulse |
| reqVa | input | VA_W | Virtual address |
| reqAsid | input | ASID_W | Current ASID |
| reqWrite | input | 1 | 1 = store access |
| done | output | 1 | Result valid pulse |
| xlatOk | output | 1 | Translation succeeded |
| paddr | output | PFN_W+12 | Physical address |
| writable | output | 1 | Page dirty bit |
| excValid | output | 1 | Exception raised |
| excCode | output | 2 | 1 modify, 2 load miss/invalid, 3 store miss/invalid |
| refill | output | 1 | No slot matched |
| cfgErr | output | 1 | Sticky unsupported-mask flag |

## Verification
Every result is due a fixed number of edges after `start` is accepted. A match at walk position k arrives k+1 edges later, and a full miss arrives N edges later. The bench drives inputs and samples outputs on falling edges, counts rising edges until `done` is seen, and compares that count with the position its own slot model predicts. It also checks that `done` does not come early. The flag `cfgErr` is checked one falling edge after the faulty write, and again after later writes.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

  localparam int MASK_W    = 25;
  localparam int OFF_W     = 12;
  localparam int PAIR_LSB  = 13;
  localparam int NUM_SIZES = 7;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_MOD  = 2'd1,
    EXC_LOAD = 2'd2,
    EXC_STORE = 2'd3
  } exc_e;

  typedef struct packed {
    logic latchReq;
    logic capHit;
    logic capMiss;
  } strobe_t;

  typedef struct packed {
    logic [4:0] shift;
    logic       ok;
  } pshift_t;

  function automatic pshift_t decodeMask(input logic [MASK_W-1:0] m);
    pshift_t r;
    logic [MASK_W-1:0] f;
    r.shift = 5'(OFF_W);
    r.ok    = 1'b0;
    f = m | MASK_W'((64'd1 << PAIR_LSB) - 64'd1);
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (f == MASK_W'((64'd1 << (PAIR_LSB + 2 * k)) - 64'd1)) begin
        r.shift = 5'(OFF_W + 2 * k);
        r.ok    = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import pair_tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VA_W   = 32,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24,
  parameter int IDX_W  = $clog2(N),
  localparam int VPN2_W = VA_W - PAIR_LSB,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [MASK_W-1:0] wrMask,
  input  logic [VPN2_W-1:0] wrVpn2,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [PFN_W-1:0]  wrPfn0,
  input  logic              wrValid0,
  input  logic              wrDirty0,
  input  logic [PFN_W-1:0]  wrPfn1,
  input  logic              wrValid1,
  input  logic              wrDirty1,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              reqWrite,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  scanIdx,
  output logic              entryMatch,
  output logic              done,
  output logic              xlatOk,
  output logic [PA_W-1:0]   paddr,
  output logic              writable,
  output logic              excValid,
  output logic [1:0]        excCode,
  output logic              refill,
  output logic              cfgErr
);

  logic [MASK_W-1:0] maskQ  [N];
  logic [VPN2_W-1:0] vpn2Q  [N];
  logic [ASID_W-1:0] asidQ  [N];
  logic              globQ  [N];
  logic [PFN_W-1:0]  pfnQ   [N][2];
  logic              validQ [N][2];
  logic              dirtyQ [N][2];

  logic [VA_W-1:0]   rVa;
  logic [ASID_W-1:0] rAsid;
  logic              rWrite;

  // slot storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        maskQ[i] <= '0;
        vpn2Q[i] <= '0;
        asidQ[i] <= '0;
        globQ[i] <= 1'b0;
        for (int h = 0; h < 2; h++) begin
          pfnQ[i][h]   <= '0;
          validQ[i][h] <= 1'b0;
          dirtyQ[i][h] <= 1'b0;
        end
      end
    end else if (wrEn) begin
      maskQ[wrIdx]     <= wrMask;
      vpn2Q[wrIdx]     <= wrVpn2;
      asidQ[wrIdx]     <= wrAsid;
      globQ[wrIdx]     <= wrGlobal;
      pfnQ[wrIdx][0]   <= wrPfn0;
      validQ[wrIdx][0] <= wrValid0;
      dirtyQ[wrIdx][0] <= wrDirty0;
      pfnQ[wrIdx][1]   <= wrPfn1;
      validQ[wrIdx][1] <= wrValid1;
      dirtyQ[wrIdx][1] <= wrDirty1;
    end
  end

  // sticky configuration error
  pshift_t wrShift;
  assign wrShift = decodeMask(wrMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cfgErr <= 1'b0;
    else if (wrEn && !wrShift.ok)   cfgErr <= 1'b1;
  end

  // request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rVa    <= '0;
      rAsid  <= '0;
      rWrite <= 1'b0;
    end else if (strb.latchReq) begin
      rVa    <= reqVa;
      rAsid  <= reqAsid;
      rWrite <= reqWrite;
    end
  end

  // compare of the slot under scan
  pshift_t           curShift;
  logic [VA_W-1:0]   lowMask;
  logic [VA_W-1:0]   hiMask;
  logic [VA_W-1:0]   entryVa;
  logic              oddSel;
  logic [PFN_W-1:0]  selPfn;
  logic              selValid;
  logic              selDirty;
  logic [PA_W-1:0]   transPa;

  always_comb begin
    curShift = decodeMask(maskQ[scanIdx]);
    lowMask  = (VA_W'(1) << curShift.shift) - VA_W'(1);
    hiMask   = ~{lowMask[VA_W-2:0], 1'b1};
    entryVa  = {vpn2Q[scanIdx], {PAIR_LSB{1'b0}}};
    entryMatch = (((entryVa ^ rVa) & hiMask) == '0) &&
                 (globQ[scanIdx] || (asidQ[scanIdx] == rAsid));
    oddSel   = rVa[curShift.shift];
    selPfn   = pfnQ[scanIdx][oddSel];
    selValid = validQ[scanIdx][oddSel];
    selDirty = dirtyQ[scanIdx][oddSel];
    transPa  = ({selPfn, {OFF_W{1'b0}}} & ~PA_W'(lowMask)) | PA_W'(rVa & lowMask);
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      xlatOk   <= 1'b0;
      paddr    <= '0;
      writable <= 1'b0;
      excValid <= 1'b0;
      excCode  <= EXC_NONE;
      refill   <= 1'b0;
    end else begin
      done <= strb.capHit | strb.capMiss;
      if (strb.capHit) begin
        refill <= 1'b0;
        if (!selValid) begin
          xlatOk   <= 1'b0;
          writable <= 1'b0;
          excValid <= 1'b1;
          excCode  <= rWrite ? EXC_STORE : EXC_LOAD;
        end else if (rWrite && !selDirty) begin
          xlatOk   <= 1'b0;
          writable <= 1'b0;
          excValid <= 1'b1;
          excCode  <= EXC_MOD;
        end else begin
          xlatOk   <= 1'b1;
          paddr    <= transPa;
          writable <= selDirty;
          excValid <= 1'b0;
          excCode  <= EXC_NONE;
        end
      end else if (strb.capMiss) begin
        xlatOk   <= 1'b0;
        writable <= 1'b0;
        excValid <= 1'b1;
        refill   <= 1'b1;
        excCode  <= rWrite ? EXC_STORE : EXC_LOAD;
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_ok_xor_exc_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (xlatOk != excValid));
  assert_writable_needs_ok_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && writable) |-> xlatOk);
  assert_refill_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && refill) |-> (excValid && excCode != EXC_MOD));
  assert_mod_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && excCode == EXC_MOD) |-> (rWrite && !refill));
  assert_cfg_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

endmodule

// File: rtl/tlb_scan_ctrl.sv
module tlb_scan_ctrl
  import pair_tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             start,
  input  logic             entryMatch,
  output strobe_t          strb,
  output logic [IDX_W-1:0] scanIdx
);

  typedef enum logic {ST_IDLE, ST_SCAN} state_e;

  state_e           state;
  logic [IDX_W-1:0] lastWr;
  logic [IDX_W-1:0] visited;
  logic             lastVisit;

  assign lastVisit = (visited == IDX_W'(N - 1));

  always_comb begin
    strb = '0;
    strb.latchReq = (state == ST_IDLE) && start;
    strb.capHit   = (state == ST_SCAN) && entryMatch;
    strb.capMiss  = (state == ST_SCAN) && !entryMatch && lastVisit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lastWr <= '0;
    else if (wrEn) lastWr <= wrIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
      visited <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SCAN;
          scanIdx <= lastWr;
          visited <= '0;
        end
        ST_SCAN: begin
          if (strb.capHit || strb.capMiss) begin
            state <= ST_IDLE;
          end else begin
            scanIdx <= (scanIdx == IDX_W'(N - 1)) ? '0 : scanIdx + 1'b1;
            visited <= visited + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> (32'(scanIdx) < N));
  assert_step_wraps_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && !strb.capHit && !strb.capMiss) |=>
      (32'(scanIdx) == ((32'($past(scanIdx)) + 1) % N)));
  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && start) |-> !strb.latchReq);

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VA_W   = 32,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24,
  localparam int IDX_W  = $clog2(N),
  localparam int VPN2_W = VA_W - PAIR_LSB,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [MASK_W-1:0] wrMask,
  input  logic [VPN2_W-1:0] wrVpn2,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [PFN_W-1:0]  wrPfn0,
  input  logic              wrValid0,
  input  logic              wrDirty0,
  input  logic [PFN_W-1:0]  wrPfn1,
  input  logic              wrValid1,
  input  logic              wrDirty1,
  input  logic              start,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              reqWrite,
  output logic              done,
  output logic              xlatOk,
  output logic [PA_W-1:0]   paddr,
  output logic              writable,
  output logic              excValid,
  output logic [1:0]        excCode,
  output logic              refill,
  output logic              cfgErr
);

  strobe_t          strb;
  logic [IDX_W-1:0] scanIdx;
  logic             entryMatch;

  tlb_scan_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .start(start),
    .entryMatch(entryMatch), .strb(strb), .scanIdx(scanIdx)
  );

  tlb_datapath #(.N(N), .VA_W(VA_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrMask(wrMask), .wrVpn2(wrVpn2),
    .wrAsid(wrAsid), .wrGlobal(wrGlobal),
    .wrPfn0(wrPfn0), .wrValid0(wrValid0), .wrDirty0(wrDirty0),
    .wrPfn1(wrPfn1), .wrValid1(wrValid1), .wrDirty1(wrDirty1),
    .reqVa(reqVa), .reqAsid(reqAsid), .reqWrite(reqWrite),
    .strb(strb), .scanIdx(scanIdx), .entryMatch(entryMatch),
    .done(done), .xlatOk(xlatOk), .paddr(paddr), .writable(writable),
    .excValid(excValid), .excCode(excCode), .refill(refill), .cfgErr(cfgErr)
  );

endmodule

// File: tb/pair_tlb_tb.sv
module pair_tlb_tb;
  localparam int N = 16;
  localparam int VA_W = 32;
  localparam int ASID_W = 8;
  localparam int PFN_W = 24;
  localparam int IDX_W = $clog2(N);
  localparam int PA_W = PFN_W + 12;

  logic clk = 0;
  logic rstN = 0;
  always #10 clk = ~clk;

  logic wrEn = 0; logic [IDX_W-1:0] wrIdx = '0; logic [24:0] wrMask = '0;
  logic [VA_W-14:0] wrVpn2 = '0; logic [ASID_W-1:0] wrAsid = '0; logic wrGlobal = 0;
  logic [PFN_W-1:0] wrPfn0 = '0, wrPfn1 = '0;
  logic wrValid0 = 0, wrDirty0 = 0, wrValid1 = 0, wrDirty1 = 0;
  logic start = 0; logic [VA_W-1:0] reqVa = '0; logic [ASID_W-1:0] reqAsid = '0; logic reqWrite = 0;
  logic done, xlatOk, writable, excValid, refill, cfgErr;
  logic [PA_W-1:0] paddr; logic [1:0] excCode;

  pair_tlb u_dut (.*);

  int nChk = 0, nBad = 0;
  bit finished = 0;

  // shadow slots
  longint mMask[N], mVa[N], mPfn[N][2];
  int mAsid[N]; bit mG[N], mV[N][2], mD[N][2];
  int lastWrM = 0;
  bit eOk, eWr, eRef; longint ePa; int eCode, eLat;

  task automatic chk(bit good, string req, longint act, longint exp);
    nChk++;
    if (!good) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int shiftOf(longint m);
    longint f = m | 64'h1fff;
    for (int k = 0; k < 7; k++)
      if (f == (64'd1 << (13 + 2 * k)) - 1) return 12 + 2 * k;
    return 12;
  endfunction

  task automatic model(longint va, int asid, bit w);
    for (int k = 0; k < N; k++) begin
      int i = (lastWrM + k) % N;
      int s = shiftOf(mMask[i]);
      longint low = (64'd1 << s) - 1;
      if ((((mVa[i] ^ va) >> (s + 1)) == 0) && (mG[i] || mAsid[i] == asid)) begin
        int h = int'((va >> s) & 1);
        eLat = k + 2; eRef = 0; eOk = 0; eWr = 0; ePa = 0;
        if (!mV[i][h]) eCode = w ? 3 : 2;
        else if (w && !mD[i][h]) eCode = 1;
        else begin
          eOk = 1; eCode = 0; eWr = mD[i][h];
          ePa = ((mPfn[i][h] << 12) & ~low) | (va & low);
        end
        return;
      end
    end
    eLat = N + 1; eOk = 0; eWr = 0; eRef = 1; eCode = w ? 3 : 2; ePa = 0;
  endtask

  task automatic writeSlot(int i, longint msk, longint va, int asid, bit g,
                           longint p0, bit v0, bit d0, longint p1, bit v1, bit d1);
    @(negedge clk);
    wrEn = 1; wrIdx = IDX_W'(i); wrMask = 25'(msk); wrVpn2 = (VA_W-13)'(va >> 13);
    wrAsid = ASID_W'(asid); wrGlobal = g;
    wrPfn0 = PFN_W'(p0); wrValid0 = v0; wrDirty0 = d0;
    wrPfn1 = PFN_W'(p1); wrValid1 = v1; wrDirty1 = d1;
    mMask[i] = msk; mVa[i] = (va >> 13) << 13; mAsid[i] = asid; mG[i] = g;
    mPfn[i][0] = p0; mV[i][0] = v0; mD[i][0] = d0;
    mPfn[i][1] = p1; mV[i][1] = v1; mD[i][1] = d1;
    lastWrM = i;
    @(negedge clk);
    wrEn = 0;
  endtask

  // midStart: pulse start again during the walk with another address (R11)
  task automatic lookup(longint va, int asid, bit w, string req, bit midStart = 0);
    int lat = 0;
    model(va, asid, w);
    @(negedge clk);
    start = 1; reqVa = VA_W'(va); reqAsid = ASID_W'(asid); reqWrite = w;
    for (;;) begin
      @(posedge clk); lat++;
      @(negedge clk);
      start = 0;
      if (midStart && lat == 1) begin
        start = 1; reqVa = VA_W'(va ^ 64'h4000_0000); reqWrite = ~w;
      end
      if (done || lat > N + 4) break;
    end
    start = 0;
    chk(lat == eLat, {req, " latency(R2)"}, lat, eLat);
    chk(xlatOk == eOk, {req, " ok"}, xlatOk, eOk);
    if (eOk) begin
      chk(paddr == PA_W'(ePa), {req, " paddr(R5)"}, paddr, ePa);
      chk(writable == eWr, {req, " writable(R5)"}, writable, eWr);
    end else begin
      chk(excValid && excCode == 2'(eCode), {req, " excCode"}, excCode, eCode);
      chk(refill == eRef, {req, " refill"}, refill, eRef);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mMask[i] = 0; mVa[i] = 0; mAsid[i] = 0; mG[i] = 0;
      for (int h = 0; h < 2; h++) begin mPfn[i][h] = 0; mV[i][h] = 0; mD[i][h] = 0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk(!done && !xlatOk && !excValid && !refill, "R1 outputs idle", done, 0);
    chk(!cfgErr, "R1 cfgErr clear", cfgErr, 0);
    // R1/R8: empty table -> refill miss walking from slot 0
    lookup(64'h0123_4000, 5, 0, "R1 R8 empty read");
    lookup(64'h0123_4000, 5, 1, "R8 empty write");

    // R3/R5/R7: one slot per page size, even half dirty, odd half clean
    for (int p = 0; p < 7; p++) begin
      longint base = longint'(p + 1) << 26;
      writeSlot(p, (64'd1 << (13 + 2 * p)) - 1, base, p + 1, 0,
                64'h100 + p * 64'h37, 1, 1, 64'h8000 + p * 64'h91, 1, 0);
    end
    for (int p = 0; p < 7; p++) begin
      int s = 12 + 2 * p;
      longint base = longint'(p + 1) << 26;
      for (int h = 0; h < 2; h++) begin
        longint va = base | (longint'(h) << s) | (64'h00AB_CDEF & ((64'd1 << s) - 1));
        lookup(va, p + 1, 0, "R3 R5 read sweep");
        lookup(va, p + 1, 1, "R5 R7 write sweep");
        lookup(va | 64'd1, p + 1, 0, "R3 R5 offset low bit");
      end
      // R4: bit just above the pair breaks the match
      lookup(base | (64'd1 << (s + 1)), p + 1, 0, "R4 tag bit above pair");
      // R4: ASID mismatch without global -> refill
      lookup(base, p + 9, 0, "R4 asid mismatch");
    end

    // R4: global slot ignores ASID
    writeSlot(8, 0, 64'd8 << 26, 33, 1, 64'h777, 1, 1, 64'h778, 1, 1);
    lookup((64'd8 << 26) | 64'h1234, 99, 1, "R4 global even");
    lookup((64'd8 << 26) | 64'h1234 | 64'h1000, 7, 0, "R4 global odd");

    // R6: invalid halves
    writeSlot(9, 0, 64'd9 << 26, 4, 0, 64'h55, 0, 1, 64'h56, 0, 0);
    lookup((64'd9 << 26) | 64'h10, 4, 0, "R6 invalid read");
    lookup((64'd9 << 26) | 64'h1010, 4, 1, "R6 invalid write");

    // R9/R2: duplicate tags, most recently written slot is visited first
    writeSlot(10, 0, 64'd10 << 26, 2, 0, 64'hA0, 1, 1, 64'hA1, 1, 1);
    writeSlot(11, 0, 64'd10 << 26, 2, 0, 64'hB0, 1, 1, 64'hB1, 1, 1);
    lookup((64'd10 << 26) | 64'h88, 2, 0, "R9 newest duplicate wins");
    writeSlot(10, 0, 64'd10 << 26, 2, 0, 64'hC0, 1, 1, 64'hC1, 1, 1);
    lookup((64'd10 << 26) | 64'h1088, 2, 0, "R9 rewritten duplicate wins");
    // R2: wrap-around reaches slots below the start
    lookup((64'd1 << 26) | 64'h5, 1, 0, "R2 wrap to low slot");

    // R10: unsupported mask -> 4 KB and sticky error
    writeSlot(12, 64'h3000, 64'd12 << 26, 3, 0, 64'hD0, 1, 1, 64'hD1, 1, 0);
    chk(cfgErr == 1, "R10 cfgErr set", cfgErr, 1);
    lookup((64'd12 << 26) | 64'h1ABC, 3, 0, "R10 treated as 4KB odd");
    lookup((64'd12 << 26) | 64'h2ABC, 3, 0, "R10 beyond 8KB pair misses");
    writeSlot(13, 0, 64'd13 << 26, 3, 0, 64'hE0, 1, 1, 64'hE1, 1, 1);
    chk(cfgErr == 1, "R10 cfgErr sticky", cfgErr, 1);

    // R11: start during a walk is ignored
    lookup((64'd5 << 26) | 64'h321, 5, 0, "R11 busy start ignored", 1);
    lookup(64'h7000_0000, 5, 1, "R11 R8 busy start on miss", 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule